// File: doc/BRIEF.md
# Six-stage pipeline hazard and bypass controller

This block decides, every cycle, whether the instruction in the decode stage of an in-order six-stage integer pipeline (fetch, decode, execute, memory-read, memory-write, write-back) may advance. It also chooses where each operand consumer takes its value from. It is purely combinational. It looks at the register numbers, the class flags and the valid bit of the instruction in each stage from decode to write-back.

Operands are consumed at three different points. A branch compares its two registers in decode. An ordinary instruction uses its operands in execute. A store sends its data register to memory in memory-write. Results become available at different times. An ALU result exists at the end of execute. Load data exists only at the end of memory-read. The stall distances follow from these timings.

When `stall` is high, the surrounding pipeline holds the program counter and the fetch/decode register and loads a bubble into execute. This block has no data stream of its own, so every pin is a plain level signal with no handshake.

Top module: `hazard_unit6`

## Requirements
- R1: With a valid load in execute writing register r (r not 0), a valid non-branch instruction in decode that uses r as an execute operand raises `stall`. Such an operand is rs, or rt when the instruction is not a store. A load followed directly by a dependent instruction therefore costs exactly one stall cycle.
- R2: A valid branch in decode whose used source equals the destination of a valid ALU or load instruction in execute raises `stall`.
- R3: A valid branch in decode whose used source equals the destination of a valid load in memory-read raises `stall`. If the producer in memory-read is an ALU instruction, there is no stall, and that operand's decode select is 1 (memory-read bypass).
- R4: A decode branch select is 2 when the nearest matching producer is in memory-write, whether it is a load or an ALU instruction. It is 0 when the only match is in write-back, or when nothing matches, because the register file writes before it is read in the same cycle. The selects are `fwd_id_a` for rs and `fwd_id_b` for rt.
- R5: A store whose only dependency on a load in execute is its data register (rt) does not stall.
- R6: For each execute operand, `fwd_ex_a` (rs) or `fwd_ex_b` (rt) is 1 for a memory-read ALU producer. Otherwise it is 2 for a memory-write ALU or load producer, otherwise 3 for a write-back producer, and otherwise 0. The youngest producer wins, and a load in memory-read is never a source.
- R7: `fwd_mw_st` is 1 when a valid store in memory-write has a data register that equals the destination of a valid ALU or load instruction in write-back. Otherwise it is 0.
- R8: Register 0 never creates a dependency. Stages whose valid bit is 0 are ignored, both as consumers and as producers. With decode invalid, `stall` is 0.
- R9: A load followed directly by a branch on its result stalls two cycles. With one unrelated instruction between them it stalls one cycle. An ALU result compared by the next branch stalls one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | REG_W | Decode first source register |
| id_rt | input | REG_W | Decode second source register |
| id_use_rs | input | 1 | Decode instruction reads rs |
| id_use_rt | input | 1 | Decode instruction reads rt |
| id_branch | input | 1 | Decode instruction is a branch |
| id_store | input | 1 | Decode instruction is a store |
| ex_valid | input | 1 | Execute stage valid |
| ex_rs | input | REG_W | Execute first source register |
| ex_rt | input | REG_W | Execute second source register |
| ex_use_rs | input | 1 | Execute instruction reads rs |
| ex_use_rt | input | 1 | Execute instruction reads rt |
| ex_rd | input | REG_W | Execute destination register |
| ex_alu | input | 1 | Execute instruction is an ALU writer |
| ex_load | input | 1 | Execute instruction is a load |
| mr_valid | input | 1 | Memory-read stage valid |
| mr_rd | input | REG_W | Memory-read destination register |
| mr_alu | input | 1 | Memory-read instruction is an ALU writer |
| mr_load | input | 1 | Memory-read instruction is a load |
| mw_valid | input | 1 | Memory-write stage valid |
| mw_rt | input | REG_W | Memory-write store data register |
| mw_store | input | 1 | Memory-write instruction is a store |
| mw_rd | input | REG_W | Memory-write destination register |
| mw_alu | input | 1 | Memory-write instruction is an ALU writer |
| mw_load | input | 1 | Memory-write instruction is a load |
| wb_valid | input | 1 | Write-back stage valid |
| wb_rd | input | REG_W | Write-back destination register |
| wb_alu | input | 1 | Write-back instruction is an ALU writer |
| wb_load | input | 1 | Write-back instruction is a load |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |
| fwd_id_a | output | 2 | Decode comparator rs source: 0 file, 1 memory-read, 2 memory-write |
| fwd_id_b | output | 2 | Decode comparator rt source, same coding |
| fwd_ex_a | output | 2 | Execute rs source: 0 pipe, 1 memory-read, 2 memory-write, 3 write-back |
| fwd_ex_b | output | 2 | Execute rt source, same coding |
| fwd_mw_st | output | 1 | Store data from write-back result |

## Verification
The assertions assume the stage inputs describe a real pipeline. Each stage carries at most one class flag, a store or branch never claims to write a register, and the stage contents only move forward as the stall output allows. The bench keeps within this by generating instructions from a small record and shifting them through a behavioural model of the six stages. That model holds decode and inserts a bubble whenever its own expected stall is high. Invalid entries and register 0 are included deliberately, with fields that would otherwise match.

// File: rtl/hz6_pkg.sv
package hz6_pkg;
  // decode comparator operand source
  typedef enum logic [1:0] {
    ID_RF = 2'd0,
    ID_MR = 2'd1,
    ID_MW = 2'd2
  } id_src_e;

  // execute operand source
  typedef enum logic [1:0] {
    EX_PIPE = 2'd0,
    EX_MR   = 2'd1,
    EX_MW   = 2'd2,
    EX_WB   = 2'd3
  } ex_src_e;

  localparam int OPS   = 2; // source operands per instruction
  localparam int PRODS = 3; // producer stages visible to execute
endpackage

// File: rtl/hz6_match.sv
module hz6_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             prod_valid,
  input  logic             prod_wr,
  input  logic [REG_W-1:0] prod_rd,
  output logic             hit
);
  // register zero is hardwired and never a real dependency
  assign hit = used && prod_valid && prod_wr &&
               (prod_rd == src) && (prod_rd != '0);
endmodule

// File: rtl/hz6_id_sel.sv
module hz6_id_sel
  import hz6_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             ex_valid,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mr_valid,
  input  logic             mr_alu,
  input  logic             mr_load,
  input  logic [REG_W-1:0] mr_rd,
  input  logic             mw_valid,
  input  logic             mw_wr,
  input  logic [REG_W-1:0] mw_rd,
  output logic [1:0]       sel,
  output logic             stall_req
);
  logic ex_hit, mr_ld_hit, mr_alu_hit, mw_hit;

  hz6_match #(.REG_W(REG_W)) u_ex (
    .src(src), .used(used), .prod_valid(ex_valid), .prod_wr(ex_wr),
    .prod_rd(ex_rd), .hit(ex_hit));
  hz6_match #(.REG_W(REG_W)) u_mr_ld (
    .src(src), .used(used), .prod_valid(mr_valid), .prod_wr(mr_load),
    .prod_rd(mr_rd), .hit(mr_ld_hit));
  hz6_match #(.REG_W(REG_W)) u_mr_alu (
    .src(src), .used(used), .prod_valid(mr_valid), .prod_wr(mr_alu),
    .prod_rd(mr_rd), .hit(mr_alu_hit));
  hz6_match #(.REG_W(REG_W)) u_mw (
    .src(src), .used(used), .prod_valid(mw_valid), .prod_wr(mw_wr),
    .prod_rd(mw_rd), .hit(mw_hit));

  // nothing computed in execute is ready for a decode compare,
  // and load data in memory-read exists only at the cycle end
  assign stall_req = ex_hit || mr_ld_hit;

  always_comb begin
    sel = ID_RF;
    if (mr_alu_hit)  sel = ID_MR;
    else if (mw_hit) sel = ID_MW;
  end
endmodule

// File: rtl/hz6_ex_sel.sv
module hz6_ex_sel
  import hz6_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic             mr_valid,
  input  logic             mr_alu,
  input  logic [REG_W-1:0] mr_rd,
  input  logic             mw_valid,
  input  logic             mw_wr,
  input  logic [REG_W-1:0] mw_rd,
  input  logic             wb_valid,
  input  logic             wb_wr,
  input  logic [REG_W-1:0] wb_rd,
  output logic [1:0]       sel
);
  logic [PRODS-1:0] pv, pw, hit;
  logic [REG_W-1:0] prd [PRODS];

  // index 0 is the youngest producer
  assign pv = {wb_valid, mw_valid, mr_valid};
  assign pw = {wb_wr, mw_wr, mr_alu};
  assign prd[0] = mr_rd;
  assign prd[1] = mw_rd;
  assign prd[2] = wb_rd;

  for (genvar k = 0; k < PRODS; k++) begin : g_prod
    hz6_match #(.REG_W(REG_W)) u_m (
      .src(src), .used(used), .prod_valid(pv[k]), .prod_wr(pw[k]),
      .prod_rd(prd[k]), .hit(hit[k]));
  end

  always_comb begin
    sel = EX_PIPE;
    if (hit[0])      sel = EX_MR;
    else if (hit[1]) sel = EX_MW;
    else if (hit[2]) sel = EX_WB;
  end
endmodule

// File: rtl/hazard_unit6.sv
module hazard_unit6
  import hz6_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic             id_branch,
  input  logic             id_store,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic             ex_use_rs,
  input  logic             ex_use_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_alu,
  input  logic             ex_load,
  input  logic             mr_valid,
  input  logic [REG_W-1:0] mr_rd,
  input  logic             mr_alu,
  input  logic             mr_load,
  input  logic             mw_valid,
  input  logic [REG_W-1:0] mw_rt,
  input  logic             mw_store,
  input  logic [REG_W-1:0] mw_rd,
  input  logic             mw_alu,
  input  logic             mw_load,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_alu,
  input  logic             wb_load,
  output logic             stall,
  output logic [1:0]       fwd_id_a,
  output logic [1:0]       fwd_id_b,
  output logic [1:0]       fwd_ex_a,
  output logic [1:0]       fwd_ex_b,
  output logic             fwd_mw_st
);
  logic             ex_wr, mw_wr, wb_wr;
  logic [REG_W-1:0] id_src [OPS];
  logic [REG_W-1:0] ex_src [OPS];
  logic [OPS-1:0]   id_use, ex_use, lu_use, br_use, lu_hit, br_req;
  logic [1:0]       id_sel [OPS];
  logic [1:0]       ex_sel [OPS];

  assign ex_wr = ex_alu || ex_load;
  assign mw_wr = mw_alu || mw_load;
  assign wb_wr = wb_alu || wb_load;

  assign id_src[0] = id_rs;
  assign id_src[1] = id_rt;
  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;
  assign id_use    = {id_use_rt, id_use_rs};
  assign ex_use    = {ex_use_rt, ex_use_rs};

  // execute-time consumers in decode: a store's data goes to memory-write
  assign lu_use[0] = id_valid && id_use[0] && !id_branch;
  assign lu_use[1] = id_valid && id_use[1] && !id_branch && !id_store;
  // decode-time consumers: branch comparator
  assign br_use    = {OPS{id_valid && id_branch}} & id_use;

  for (genvar op = 0; op < OPS; op++) begin : g_op
    hz6_match #(.REG_W(REG_W)) u_lu (
      .src(id_src[op]), .used(lu_use[op]), .prod_valid(ex_valid),
      .prod_wr(ex_load), .prod_rd(ex_rd), .hit(lu_hit[op]));

    hz6_id_sel #(.REG_W(REG_W)) u_idsel (
      .src(id_src[op]), .used(br_use[op]),
      .ex_valid(ex_valid), .ex_wr(ex_wr), .ex_rd(ex_rd),
      .mr_valid(mr_valid), .mr_alu(mr_alu), .mr_load(mr_load), .mr_rd(mr_rd),
      .mw_valid(mw_valid), .mw_wr(mw_wr), .mw_rd(mw_rd),
      .sel(id_sel[op]), .stall_req(br_req[op]));

    hz6_ex_sel #(.REG_W(REG_W)) u_exsel (
      .src(ex_src[op]), .used(ex_valid && ex_use[op]),
      .mr_valid(mr_valid), .mr_alu(mr_alu), .mr_rd(mr_rd),
      .mw_valid(mw_valid), .mw_wr(mw_wr), .mw_rd(mw_rd),
      .wb_valid(wb_valid), .wb_wr(wb_wr), .wb_rd(wb_rd),
      .sel(ex_sel[op]));
  end

  hz6_match #(.REG_W(REG_W)) u_stfwd (
    .src(mw_rt), .used(mw_valid && mw_store), .prod_valid(wb_valid),
    .prod_wr(wb_wr), .prod_rd(wb_rd), .hit(fwd_mw_st));

  assign stall    = (|lu_hit) || (|br_req);
  assign fwd_id_a = id_sel[0];
  assign fwd_id_b = id_sel[1];
  assign fwd_ex_a = ex_sel[0];
  assign fwd_ex_b = ex_sel[1];
endmodule

// File: rtl/hz6_chk.sv
module hz6_chk #(
  parameter int REG_W = 5
) (
  input logic             id_valid,
  input logic [REG_W-1:0] id_rs,
  input logic             id_use_rs,
  input logic             id_branch,
  input logic             ex_valid,
  input logic [REG_W-1:0] ex_rs,
  input logic             ex_use_rs,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_alu,
  input logic             ex_load,
  input logic             mr_valid,
  input logic [REG_W-1:0] mr_rd,
  input logic             mr_alu,
  input logic             mw_valid,
  input logic [REG_W-1:0] mw_rt,
  input logic             mw_store,
  input logic [REG_W-1:0] mw_rd,
  input logic             mw_alu,
  input logic             mw_load,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_alu,
  input logic             wb_load,
  input logic             stall,
  input logic [1:0]       fwd_id_a,
  input logic [1:0]       fwd_ex_a,
  input logic             fwd_mw_st
);
  always_comb begin
    // R1
    if (id_valid && ex_valid && ex_load && ex_rd != '0 && !id_branch &&
        id_use_rs && id_rs == ex_rd)
      ld_use_stall_chk: assert (stall);
    // R2
    if (id_valid && ex_valid && (ex_alu || ex_load) && ex_rd != '0 &&
        id_branch && id_use_rs && id_rs == ex_rd)
      br_ex_stall_chk: assert (stall);
    // R8
    if (!id_valid)
      idle_no_stall_chk: assert (!stall);
    // R6
    if (fwd_ex_a == 2'd1)
      ex_mr_src_chk: assert (ex_valid && ex_use_rs && mr_valid && mr_alu &&
                             mr_rd == ex_rs && ex_rs != '0);
    // R4
    if (fwd_id_a == 2'd2)
      id_mw_src_chk: assert (id_valid && id_branch && mw_valid &&
                             (mw_alu || mw_load) && mw_rd == id_rs);
    // R7
    if (fwd_mw_st)
      st_wb_fwd_chk: assert (mw_valid && mw_store && wb_valid &&
                             (wb_alu || wb_load) && wb_rd == mw_rt &&
                             mw_rt != '0);
  end
endmodule

bind hazard_unit6 hz6_chk #(.REG_W(REG_W)) u_chk (
  .id_valid(id_valid), .id_rs(id_rs), .id_use_rs(id_use_rs),
  .id_branch(id_branch), .ex_valid(ex_valid), .ex_rs(ex_rs),
  .ex_use_rs(ex_use_rs), .ex_rd(ex_rd), .ex_alu(ex_alu), .ex_load(ex_load),
  .mr_valid(mr_valid), .mr_rd(mr_rd), .mr_alu(mr_alu),
  .mw_valid(mw_valid), .mw_rt(mw_rt), .mw_store(mw_store), .mw_rd(mw_rd),
  .mw_alu(mw_alu), .mw_load(mw_load), .wb_valid(wb_valid), .wb_rd(wb_rd),
  .wb_alu(wb_alu), .wb_load(wb_load), .stall(stall), .fwd_id_a(fwd_id_a),
  .fwd_ex_a(fwd_ex_a), .fwd_mw_st(fwd_mw_st));

// File: tb/sim_hazard_unit6.sv
module sim_hazard_unit6;
  localparam int RW = 5;
  // instruction classes
  localparam int C_ALU = 0, C_LD = 1, C_ST = 2, C_BR = 3, C_NOP = 4;

  typedef struct {
    bit    v;
    int    cls;
    int    rd, rs, rt;
    bit    urs, urt;
    int    exp;   // expected stall cycles in decode, -1 = unchecked
    string tag;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          id_valid = 0, id_use_rs = 0, id_use_rt = 0, id_branch = 0, id_store = 0;
  logic [RW-1:0] id_rs = 0, id_rt = 0;
  logic          ex_valid = 0, ex_use_rs = 0, ex_use_rt = 0, ex_alu = 0, ex_load = 0;
  logic [RW-1:0] ex_rs = 0, ex_rt = 0, ex_rd = 0;
  logic          mr_valid = 0, mr_alu = 0, mr_load = 0;
  logic [RW-1:0] mr_rd = 0;
  logic          mw_valid = 0, mw_store = 0, mw_alu = 0, mw_load = 0;
  logic [RW-1:0] mw_rt = 0, mw_rd = 0;
  logic          wb_valid = 0, wb_alu = 0, wb_load = 0;
  logic [RW-1:0] wb_rd = 0;
  logic          stall, fwd_mw_st;
  logic [1:0]    fwd_id_a, fwd_id_b, fwd_ex_a, fwd_ex_b;

  hazard_unit6 #(.REG_W(RW)) u0 (.*);

  int   n_chk = 0, n_fail = 0, cyc = 0;
  ins_t prog[$];
  ins_t st[6];           // 1 ID, 2 EX, 3 MR, 4 MW, 5 WB
  int   stall_cnt = 0;
  bit   exp_stall = 0;

  function automatic ins_t mk(bit v, int cls, int rd, int rs, int rt,
                              bit urs, bit urt, int exp, string tag);
    ins_t i;
    i.v = v; i.cls = cls; i.rd = rd; i.rs = rs; i.rt = rt;
    i.urs = urs; i.urt = urt; i.exp = exp; i.tag = tag;
    return i;
  endfunction

  function automatic ins_t bubble();
    return mk(0, C_NOP, 0, 0, 0, 0, 0, -1, "");
  endfunction

  function automatic bit writes(ins_t i, int r);
    return i.v && (i.cls == C_ALU || i.cls == C_LD) && i.rd == r && r != 0;
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  // nearest producer distance from stage s for register r, 0 = none
  function automatic int nearest(int s, int r);
    for (int d = s + 1; d <= 5; d++)
      if (writes(st[d], r)) return d;
    return 0;
  endfunction

  task automatic ref_and_compare();
    bit    s = 0;
    string why = "R1";
    int    e_ida = 0, e_idb = 0, e_exa = 0, e_exb = 0, e_mw = 0;
    ins_t  c = st[1];
    for (int op = 0; op < 2; op++) begin
      int r = (op == 0) ? c.rs : c.rt;
      bit u = (op == 0) ? c.urs : c.urt;
      if (c.v && u && r != 0) begin
        int d = nearest(1, r);
        int need;
        if (c.cls == C_BR) need = (d > 0 && st[d].cls == C_LD) ? 3 : 2;
        else if (c.cls == C_ST && op == 1) need = 0;
        else need = (d > 0 && st[d].cls == C_LD) ? 2 : 1;
        if (c.cls == C_ST && op == 1 && d == 2 && st[2].cls == C_LD) why = "R5";
        if (d > 0 && d <= need) begin
          s = 1;
          why = (c.cls == C_BR) ? ((d == 2) ? "R2" : "R3") : "R1";
        end
        if (c.cls == C_BR) begin
          int sel = (d == 3) ? 1 : (d == 4) ? 2 : 0;
          if (op == 0) e_ida = sel; else e_idb = sel;
        end
      end
    end
    for (int op = 0; op < 2; op++) begin
      int r = (op == 0) ? st[2].rs : st[2].rt;
      bit u = (op == 0) ? st[2].urs : st[2].urt;
      int sel = 0;
      if (st[2].v && u && r != 0)
        for (int e = 3; e <= 5; e++)
          if (sel == 0 && writes(st[e], r) && !(e == 3 && st[e].cls == C_LD))
            sel = e - 2;
      if (op == 0) e_exa = sel; else e_exb = sel;
    end
    if (st[4].v && st[4].cls == C_ST && writes(st[5], st[4].rt)) e_mw = 1;
    if (!c.v) why = "R8";
    check(why, int'(stall), int'(s));
    if (!s) begin
      check("R4", int'(fwd_id_a), e_ida);
      check("R4", int'(fwd_id_b), e_idb);
    end
    check("R6", int'(fwd_ex_a), e_exa);
    check("R6", int'(fwd_ex_b), e_exb);
    check("R7", int'(fwd_mw_st), e_mw);
    exp_stall = s;
  endtask

  task automatic drive();
    id_valid = st[1].v; id_rs = RW'(st[1].rs); id_rt = RW'(st[1].rt);
    id_use_rs = st[1].urs; id_use_rt = st[1].urt;
    id_branch = st[1].cls == C_BR; id_store = st[1].cls == C_ST;
    ex_valid = st[2].v; ex_rs = RW'(st[2].rs); ex_rt = RW'(st[2].rt);
    ex_use_rs = st[2].urs; ex_use_rt = st[2].urt; ex_rd = RW'(st[2].rd);
    ex_alu = st[2].cls == C_ALU; ex_load = st[2].cls == C_LD;
    mr_valid = st[3].v; mr_rd = RW'(st[3].rd);
    mr_alu = st[3].cls == C_ALU; mr_load = st[3].cls == C_LD;
    mw_valid = st[4].v; mw_rt = RW'(st[4].rt); mw_rd = RW'(st[4].rd);
    mw_store = st[4].cls == C_ST;
    mw_alu = st[4].cls == C_ALU; mw_load = st[4].cls == C_LD;
    wb_valid = st[5].v; wb_rd = RW'(st[5].rd);
    wb_alu = st[5].cls == C_ALU; wb_load = st[5].cls == C_LD;
  endtask

  task automatic advance();
    if (exp_stall) begin
      for (int k = 5; k >= 3; k--) st[k] = st[k-1];
      st[2] = bubble();
      stall_cnt++;
    end else begin
      if (st[1].exp >= 0) check(st[1].tag, stall_cnt, st[1].exp);
      for (int k = 5; k >= 2; k--) st[k] = st[k-1];
      st[1] = (prog.size() > 0) ? prog.pop_front() : bubble();
      stall_cnt = 0;
    end
  endtask

  task automatic nops();
    repeat (4) prog.push_back(mk(1, C_NOP, 0, 0, 0, 0, 0, -1, ""));
  endtask

  initial begin
    for (int k = 0; k < 6; k++) st[k] = bubble();
    // R1: load feeding an address base
    prog.push_back(mk(1, C_LD, 5, 1, 5, 1, 0, -1, ""));
    prog.push_back(mk(1, C_LD, 6, 5, 6, 1, 0, 1, "R1")); nops();
    // R9: load then branch, adjacent and with one gap
    prog.push_back(mk(1, C_LD, 7, 1, 7, 1, 0, -1, ""));
    prog.push_back(mk(1, C_BR, 0, 7, 8, 1, 1, 2, "R9")); nops();
    prog.push_back(mk(1, C_LD, 7, 1, 7, 1, 0, -1, ""));
    prog.push_back(mk(1, C_ALU, 9, 2, 3, 1, 1, 0, "R9"));
    prog.push_back(mk(1, C_BR, 0, 8, 7, 1, 1, 1, "R9")); nops();
    // R2 and R9: ALU result into the next branch
    prog.push_back(mk(1, C_ALU, 3, 1, 2, 1, 1, -1, ""));
    prog.push_back(mk(1, C_BR, 0, 3, 4, 1, 1, 1, "R2")); nops();
    // R3: ALU two ahead of branch, bypass from memory-read
    prog.push_back(mk(1, C_ALU, 3, 1, 2, 1, 1, -1, ""));
    prog.push_back(mk(1, C_ALU, 9, 2, 2, 1, 1, -1, ""));
    prog.push_back(mk(1, C_BR, 0, 4, 3, 1, 1, 0, "R3")); nops();
    // R5: load result used only as store data
    prog.push_back(mk(1, C_LD, 4, 1, 4, 1, 0, -1, ""));
    prog.push_back(mk(1, C_ST, 0, 10, 4, 1, 1, 0, "R5")); nops();
    // R1: same load used as store base
    prog.push_back(mk(1, C_LD, 4, 1, 4, 1, 0, -1, ""));
    prog.push_back(mk(1, C_ST, 0, 4, 2, 1, 1, 1, "R1")); nops();
    // R8: register zero and an invalid producer
    prog.push_back(mk(1, C_LD, 0, 1, 0, 1, 0, -1, ""));
    prog.push_back(mk(1, C_BR, 0, 0, 5, 1, 1, 0, "R8"));
    prog.push_back(mk(0, C_LD, 11, 1, 11, 1, 0, -1, ""));
    prog.push_back(mk(1, C_BR, 0, 11, 1, 1, 1, 0, "R8")); nops();
    // mixed stream over a small register set
    for (int n = 0; n < 3000; n++) begin
      int cls = $urandom_range(0, 4);
      bit v = $urandom_range(0, 9) != 0;
      int rd = (cls == C_ALU || cls == C_LD) ? $urandom_range(0, 7) : 0;
      int rs = $urandom_range(0, 7);
      int rt = (cls == C_LD) ? rd : $urandom_range(0, 7);
      prog.push_back(mk(v, cls, rd, rs, rt, cls != C_NOP,
                        cls == C_ALU || cls == C_ST || cls == C_BR, -1, ""));
    end
    drive();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: empty pipeline gives all-zero outputs
    check("R8", int'(stall), 0);
    check("R8", int'({fwd_id_a, fwd_id_b, fwd_ex_a, fwd_ex_b, fwd_mw_st}), 0);
    exp_stall = 0;
    while (prog.size() > 0 || st[1].v || st[2].v || st[3].v || st[4].v || st[5].v) begin
      @(posedge clk);
      advance();
      drive();
      @(negedge clk);
      ref_and_compare();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule